// File: doc/BRIEF.md
# Serial Receive-Line Glitch Filter

This block cleans up the asynchronous receive line of a serial port before the receiver sees it. The raw line first crosses into the clock domain through a two-flop synchroniser. It then enters a chain of three sample stages. The chain advances only on a sampling tick that runs at sixteen times the bit rate. A match detector watches the three stages. When all three hold the same level, the detector forwards that level to the filtered output. When they disagree, the output keeps its last value. This is not a majority vote. A level must stay unchanged for three consecutive ticks before it is accepted.

A small 8-bit configuration register sits beside the filter and is written from a CPU-side port. Its low three bits do the following:
- Bit 2 switches the filter on.
- Bit 1 chooses whether the transmit pin acts as a general input or as the serial output.
- Bit 0 places the channel in standby.

The filter acts only when its enable bit is set and the mode input selects asynchronous operation. In every other case the synchronised raw line goes straight to the output.

Top module: `rxLineCleaner`

## Requirements
- R1: After reset, the following hold: `rxdClean` is 1, all sample stages and the held output are 1, the three writable configuration bits are 0, and `cfgRdata` reads 8'hF8.
- R2: The sample stages advance only on a clock edge where `sampleTick` is 1. With no ticks, the filtered output does not change, whatever the line does.
- R3: When all three sample stages hold the same level, that level appears on `rxdClean` one clock after the tick that made them agree.
- R4: While the three sample stages disagree, `rxdClean` keeps its previous value. A pulse that lasts fewer than three ticks never reaches the output.
- R5: The filtered path is selected only when configuration bit 2 is 1 and `syncMode` is 0 (asynchronous). Otherwise `rxdClean` equals the synchronised raw line.
- R6: `cfgRdata` always returns 1 in bits 7..3 and the stored values in bits 2..0. Writes to bits 7..3 have no effect.
- R7: Configuration bit 0 drives `standby`. While it is 1, the sample stages and the held filter output keep their state and ignore ticks.
- R8: Configuration bit 1 drives `txPinIsOutput`. A value of 0 means the pin is a general input, and a value of 1 means it is the serial transmit output.
- R9: In bypass, a change on `rxdRaw` reaches `rxdClean` after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | One-cycle enable at 16x the bit rate |
| syncMode | input | 1 | 0 = asynchronous mode, 1 = clocked synchronous mode |
| cfgWe | input | 1 | Configuration register write strobe |
| cfgWdata | input | 8 | Configuration write data |
| cfgRdata | output | 8 | Configuration read data |
| rxdRaw | input | 1 | Unsynchronised receive line |
| rxdClean | output | 1 | Filtered (or bypassed) receive line |
| txPinIsOutput | output | 1 | Transmit pin select: 1 = serial output |
| standby | output | 1 | Channel standby indication |

## Verification
The bench applies pulses that last two ticks. A design that votes by majority, or that accepts a level after fewer than three samples, would pass these glitches to the output. It holds the line steady across long gaps without ticks, which exposes any chain that samples on every clock. It applies ticks during standby to catch stages that keep shifting. It toggles `syncMode` and the enable bit to show that bypass takes its data from the synchroniser and not from the held filter value. It also writes ones into the reserved bits and checks that reads still return ones there.

// File: rtl/rxlcPkg.sv
package rxlcPkg;
  localparam int CFG_W    = 8;
  localparam int BIT_STBY = 0;
  localparam int BIT_TXOE = 1;
  localparam int BIT_FILT = 2;
  localparam int USED_W   = 3;

  typedef struct packed {
    logic shiftEn;    // advance the sample stages
    logic matchEn;    // allow the held output to update
    logic filterSel;  // 1 = filtered path, 0 = synchronised raw
  } dpCtrlT;
endpackage

// File: rtl/rxlcControl.sv
module rxlcControl
  import rxlcPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             syncMode,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic [CFG_W-1:0] cfgRdata,
  output logic             txPinIsOutput,
  output logic             standby,
  output dpCtrlT           dpCtrl
);
  localparam int RSV_W = CFG_W - USED_W;

  logic [USED_W-1:0] cfgBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgBits <= '0;
    else if (cfgWe) cfgBits <= cfgWdata[USED_W-1:0];
  end

  assign cfgRdata      = {{RSV_W{1'b1}}, cfgBits};
  assign txPinIsOutput = cfgBits[BIT_TXOE];
  assign standby       = cfgBits[BIT_STBY];

  always_comb begin
    dpCtrl.shiftEn   = sampleTick & ~cfgBits[BIT_STBY];
    dpCtrl.matchEn   = ~cfgBits[BIT_STBY];
    dpCtrl.filterSel = cfgBits[BIT_FILT] & ~syncMode;
  end
endmodule

// File: rtl/rxlcDatapath.sv
module rxlcDatapath
  import rxlcPkg::*;
#(
  parameter int   NUM_TAPS    = 3,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LEVEL  = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxdRaw,
  input  dpCtrlT              dpCtrl,
  output logic [NUM_TAPS-1:0] taps,
  output logic                rxdClean
);
  logic [SYNC_STAGES-1:0] syncReg;
  logic                   syncOut;
  logic                   heldLevel;
  logic                   allHigh;
  logic                   allLow;

  // Synchroniser stages, stage 0 takes the raw line.
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : gSync
      if (gi == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncReg[gi] <= IDLE_LEVEL;
          else       syncReg[gi] <= rxdRaw;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncReg[gi] <= IDLE_LEVEL;
          else       syncReg[gi] <= syncReg[gi-1];
        end
      end
    end
  endgenerate

  assign syncOut = syncReg[SYNC_STAGES-1];

  // Sample chain, taps[0] is the newest sample.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               taps <= {NUM_TAPS{IDLE_LEVEL}};
    else if (dpCtrl.shiftEn) taps <= {taps[NUM_TAPS-2:0], syncOut};
  end

  assign allHigh = &taps;
  assign allLow  = ~|taps;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   heldLevel <= IDLE_LEVEL;
    else if (dpCtrl.matchEn && (allHigh || allLow)) heldLevel <= allHigh;
  end

  assign rxdClean = dpCtrl.filterSel ? heldLevel : syncOut;
endmodule

// File: rtl/rxLineCleaner.sv
module rxLineCleaner
  import rxlcPkg::*;
#(
  parameter int NUM_TAPS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             syncMode,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic [CFG_W-1:0] cfgRdata,
  input  logic             rxdRaw,
  output logic             rxdClean,
  output logic             txPinIsOutput,
  output logic             standby
);
  dpCtrlT              dpCtrl;
  logic [NUM_TAPS-1:0] taps;

  rxlcControl uCtrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .syncMode(syncMode),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .txPinIsOutput(txPinIsOutput), .standby(standby), .dpCtrl(dpCtrl)
  );

  rxlcDatapath #(.NUM_TAPS(NUM_TAPS), .SYNC_STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) uDp (
    .clk(clk), .rstN(rstN), .rxdRaw(rxdRaw), .dpCtrl(dpCtrl),
    .taps(taps), .rxdClean(rxdClean)
  );
endmodule

// File: rtl/rxLineCleanerChecker.sv
module rxLineCleanerChecker #(
  parameter int NUM_TAPS = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                sampleTick,
  input logic                syncMode,
  input logic [7:0]          cfgRdata,
  input logic                standby,
  input logic                rxdClean,
  input logic [NUM_TAPS-1:0] taps
);
  logic filterOn;
  assign filterOn = cfgRdata[2] & ~syncMode;

  AST_RESERVED_ONES: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdata[7:3] == 5'b11111);  // R6

  AST_NO_TICK_NO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sampleTick) |-> $stable(taps));  // R2

  AST_STANDBY_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    $past(standby) |-> $stable(taps));  // R7

  AST_PASS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (filterOn && $past(filterOn) && !$past(standby) && ($past(taps) == {NUM_TAPS{1'b1}}))
      |-> rxdClean);  // R3

  AST_PASS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (filterOn && $past(filterOn) && !$past(standby) && ($past(taps) == {NUM_TAPS{1'b0}}))
      |-> !rxdClean);  // R3

  AST_HOLD_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rstN)
    (filterOn && $past(filterOn) && ($past(taps) != {NUM_TAPS{1'b1}})
      && ($past(taps) != {NUM_TAPS{1'b0}})) |-> $stable(rxdClean));  // R4
endmodule

bind rxLineCleaner rxLineCleanerChecker #(.NUM_TAPS(NUM_TAPS)) uChk (
  .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .syncMode(syncMode),
  .cfgRdata(cfgRdata), .standby(standby), .rxdClean(rxdClean), .taps(taps)
);

// File: tb/rxLineCleaner_test.sv
`timescale 1ns/1ps
module rxLineCleaner_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       syncMode = 1'b0;
  logic       cfgWe = 1'b0;
  logic [7:0] cfgWdata = 8'h00;
  logic [7:0] cfgRdata;
  logic       rxdRaw = 1'b1;
  logic       rxdClean;
  logic       txPinIsOutput;
  logic       standby;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    int         kind;  // 0 clean, 1 rdata, 2 tx select, 3 standby
    logic [7:0] exp;
    string      tag;
  } expT;
  expT scoreQ[$];

  always #5 clk = ~clk;

  rxLineCleaner uut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .syncMode(syncMode),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .rxdRaw(rxdRaw), .rxdClean(rxdClean),
    .txPinIsOutput(txPinIsOutput), .standby(standby)
  );

  // Monitor: compare queued expectations one time unit after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (scoreQ.size() > 0) begin
        expT e;
        logic [7:0] act;
        e = scoreQ.pop_front();
        case (e.kind)
          0:       act = {7'd0, rxdClean};
          1:       act = cfgRdata;
          2:       act = {7'd0, txPinIsOutput};
          default: act = {7'd0, standby};
        endcase
        checks++;
        if (act !== e.exp) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", e.tag, e.kind, act, e.exp);
        end
      end
    end
  end

  task automatic expect_(input int kind, input logic [7:0] val, input string tag);
    expT e;
    e.kind = kind; e.exp = val; e.tag = tag;
    scoreQ.push_back(e);
    #2;
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseTicks(input int n);
    repeat (n) begin
      @(negedge clk); sampleTick = 1'b1;
      @(negedge clk); sampleTick = 1'b0;
    end
  endtask

  task automatic cfgWrite(input logic [7:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(1);
    expect_(0, 8'h01, "R1 clean idle high");
    expect_(1, 8'hF8, "R1 R6 reset readback");
    expect_(2, 8'h00, "R8 tx pin input after reset");
    expect_(3, 8'h00, "R7 standby clear after reset");

    cfgWrite(8'hA4);
    expect_(1, 8'hFC, "R6 reserved write ignored");

    rxdRaw = 1'b0; waitClk(3);
    pulseTicks(2); waitClk(2);
    expect_(0, 8'h01, "R4 two ticks disagree holds");
    pulseTicks(1); waitClk(2);
    expect_(0, 8'h00, "R3 three ticks accept low");

    rxdRaw = 1'b1; waitClk(3);
    pulseTicks(2); waitClk(2);
    expect_(0, 8'h00, "R4 short high glitch held");
    rxdRaw = 1'b0; waitClk(3);
    pulseTicks(3); waitClk(2);
    expect_(0, 8'h00, "R4 glitch never passed");

    rxdRaw = 1'b1; waitClk(20);
    expect_(0, 8'h00, "R2 no tick no change");
    pulseTicks(3); waitClk(2);
    expect_(0, 8'h01, "R3 three ticks accept high");

    cfgWrite(8'h05);
    expect_(3, 8'h01, "R7 standby set");
    expect_(1, 8'hFD, "R6 readback standby");
    rxdRaw = 1'b0; waitClk(3);
    pulseTicks(4); waitClk(2);
    expect_(0, 8'h01, "R7 ticks ignored in standby");
    cfgWrite(8'h04);
    expect_(3, 8'h00, "R7 standby clear");
    pulseTicks(3); waitClk(2);
    expect_(0, 8'h00, "R7 R3 resumes after standby");

    @(negedge clk); syncMode = 1'b1; rxdRaw = 1'b1;
    waitClk(3);
    expect_(0, 8'h01, "R5 sync mode bypass");
    syncMode = 1'b0;
    expect_(0, 8'h00, "R5 async mode uses held level");
    cfgWrite(8'h00);
    expect_(0, 8'h01, "R5 enable off bypass");

    @(negedge clk); rxdRaw = 1'b0;
    expect_(0, 8'h01, "R9 no change before first edge");
    @(negedge clk);
    expect_(0, 8'h01, "R9 one edge not enough");
    @(negedge clk);
    expect_(0, 8'h00, "R9 visible after two edges");

    cfgWrite(8'h02);
    expect_(2, 8'h01, "R8 tx pin output");
    expect_(1, 8'hFA, "R6 readback tx select");
    cfgWrite(8'h00);
    expect_(2, 8'h00, "R8 tx pin input");

    waitClk(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule